// File: doc/BRIEF.md
# Memory Access Wait-State Inserter

This block lengthens processor memory cycles while address translation is switched on. Rather than stretching every access, it counts qualifying accesses and asks the processor's clock logic for one extra cycle each time the count reaches a wait factor. The counter then starts again from zero. The factor depends on which translation flags are set. With a paged-translation flag or a window flag active, an access takes the memory path and the factor is 3, or 2 when the fast-translation flag is also set. With both translation flags clear, the access takes the I/O path, whose factor is a parameter that defaults to 0. A factor of 0 means no extra cycles are ever requested.

A flag reports which path the most recent counted access took. In slow clock mode the block is inert: strobes are not counted, no request is raised, and the flag keeps its value. All controls are level inputs, sampled on the clock edge where `acc_stb` is high. The outputs are plain registered status pins with no handshake.

Top module: `wait_state_inserter`

## Requirements
- R1: A synchronous `rst` clears the access count, `io_wait` and `extra_clk`, and takes priority over a strobe sampled at the same edge.
- R2: While `fast_clk` is 0, a strobe raises no request and leaves both the access count and `io_wait` unchanged.
- R3: With `fast_clk`=1, `xlat_en`=1 and `fast_xlat`=0, a request is raised on every third counted strobe.
- R4: With translation active and `fast_xlat`=1, the wait factor is 2, so every second counted strobe raises a request.
- R5: `extra_clk` is high for exactly the one cycle after the edge that samples the strobe completing the count, and the count restarts from zero at that edge.
- R6: With `xlat_en`=0 and `win_en`=0, the access takes the I/O path: `io_wait` becomes 1, and with the default I/O factor of 0 no request is raised and the count is kept.
- R7: A strobe on the memory path in fast clock mode clears `io_wait`.
- R8: A request is raised as soon as the incremented count is greater than or equal to the current factor, including when the factor has dropped below a count already held.
- R9: `win_en`=1 on its own selects the memory path with factor 3.
- R10: Cycles with `acc_stb`=0 change neither the count nor `io_wait`, and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_stb | input | 1 | One cycle per processor access |
| fast_clk | input | 1 | 1 = fast clock mode (wait insertion allowed), 0 = slow |
| xlat_en | input | 1 | Paged address translation enabled |
| win_en | input | 1 | Address window enabled |
| fast_xlat | input | 1 | Fast translation mode, shortens the memory factor |
| extra_clk | output | 1 | One-cycle request for an extra processor clock |
| io_wait | output | 1 | 1 when the last counted access took the I/O path |

## Verification
Both outputs are registered. Each result therefore belongs to the clock edge that samples its stimulus and is visible for the whole following cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and compares shortly after it. The cycle after a request is checked as well, to show that the pulse has dropped. The counter is hidden, so its retention and its restart are inferred from the strobe on which the next request appears.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
  typedef enum logic {
    PATH_MEM = 1'b0,
    PATH_IO  = 1'b1
  } wsi_path_e;

  function automatic int nonneg(input int v);
    return (v < 0) ? 0 : v;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wsi_factor_sel.sv
module wsi_factor_sel
  import wsi_pkg::*;
#(
  parameter int FW       = 2,
  parameter int MEM_F    = 3,
  parameter int FAST_F   = 2,
  parameter int IO_F     = 0
) (
  input  logic          xlat_en,
  input  logic          win_en,
  input  logic          fast_xlat,
  output logic [FW-1:0] factor,
  output wsi_path_e     path
);
  localparam logic [FW-1:0] MEM_V  = FW'(MEM_F);
  localparam logic [FW-1:0] FAST_V = FW'(FAST_F);
  localparam logic [FW-1:0] IO_V   = FW'(IO_F);

  always_comb begin
    if (xlat_en || win_en) begin
      path   = PATH_MEM;
      factor = fast_xlat ? FAST_V : MEM_V;
    end else begin
      path   = PATH_IO;
      factor = IO_V;
    end
  end
endmodule

// File: rtl/wsi_counter.sv
module wsi_counter #(
  parameter int FW    = 2,
  parameter int MAX_F = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [FW-1:0] factor,
  output logic          pulse
);
  logic [FW-1:0] cnt_q;
  logic [FW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (step && (factor != '0)) begin
        if (cnt_inc >= {1'b0, factor}) begin
          cnt_q <= '0;
          pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_inc[FW-1:0];
        end
      end
    end
  end

  // R5
  pulse_follows_step_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(step));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < ((MAX_F < 1) ? 1 : MAX_F));
endmodule

// File: rtl/wait_state_inserter.sv
module wait_state_inserter
  import wsi_pkg::*;
#(
  parameter int MEM_FACTOR  = 3,
  parameter int FAST_FACTOR = 2,
  parameter int IO_FACTOR   = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_stb,
  input  logic fast_clk,
  input  logic xlat_en,
  input  logic win_en,
  input  logic fast_xlat,
  output logic extra_clk,
  output logic io_wait
);
  localparam int MEM_C  = nonneg(MEM_FACTOR);
  localparam int FAST_C = nonneg(FAST_FACTOR);
  localparam int IO_C   = nonneg(IO_FACTOR);
  localparam int MAX_F  = max3(MEM_C, FAST_C, IO_C);
  localparam int FW     = (MAX_F < 2) ? 1 : $clog2(MAX_F + 1);

  logic [FW-1:0] factor;
  wsi_path_e     path;
  logic          step;

  assign step = acc_stb && fast_clk;

  wsi_factor_sel #(
    .FW(FW), .MEM_F(MEM_C), .FAST_F(FAST_C), .IO_F(IO_C)
  ) u_sel (
    .xlat_en  (xlat_en),
    .win_en   (win_en),
    .fast_xlat(fast_xlat),
    .factor   (factor),
    .path     (path)
  );

  wsi_counter #(.FW(FW), .MAX_F(MAX_F)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .factor(factor),
    .pulse (extra_clk)
  );

  always_ff @(posedge clk) begin
    if (rst)       io_wait <= 1'b0;
    else if (step) io_wait <= (path == PATH_IO);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!extra_clk && !io_wait));

  // R2
  slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fast_clk |=> ($stable(io_wait) && !extra_clk));

  // R7
  mem_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && fast_clk && (xlat_en || win_en)) |=> !io_wait);

  generate
    if (IO_C == 0) begin : g_io_nowait
      // R6
      io_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && fast_clk && !xlat_en && !win_en) |=> (io_wait && !extra_clk));
    end
  endgenerate
endmodule

// File: tb/wait_state_inserter_bench.sv
module wait_state_inserter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_stb = 1'b0, fast_clk = 1'b0, xlat_en = 1'b0, win_en = 1'b0, fast_xlat = 1'b0;
  logic extra_clk, io_wait;
  int   applied = 0;
  int   errors  = 0;
  bit   done    = 1'b0;

  always #4 clk = ~clk;

  wait_state_inserter u_wait_state_inserter (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .fast_clk(fast_clk),
    .xlat_en(xlat_en), .win_en(win_en), .fast_xlat(fast_xlat),
    .extra_clk(extra_clk), .io_wait(io_wait)
  );

  // bits: rst stb fast_clk xlat win fast_xlat | exp_extra exp_io
  localparam int NV = 27;
  localparam logic [7:0] VEC [NV] = '{
    8'b1000_0000, // 0  R1 reset
    8'b0111_0000, // 1  R3 count 1
    8'b0011_0000, // 2  R10 idle
    8'b0111_0000, // 3  R3 count 2
    8'b0111_0010, // 4  R3 third strobe -> request
    8'b0011_0000, // 5  R5 pulse dropped
    8'b0111_0100, // 6  R4 count 1
    8'b0111_0110, // 7  R4 second strobe -> request
    8'b0110_1000, // 8  R9 window, count 1
    8'b0110_1000, // 9  R9 count 2
    8'b0101_0000, // 10 R2 slow strobe ignored
    8'b0101_0000, // 11 R2 slow strobe ignored
    8'b0110_1010, // 12 R9 count kept through slow -> request
    8'b0110_0001, // 13 R6 io path
    8'b0110_0101, // 14 R6 io path, fast flag irrelevant
    8'b0101_0001, // 15 R2 slow keeps io flag
    8'b0111_0000, // 16 R7 memory path clears flag
    8'b0111_0000, // 17 R8 count 2
    8'b0111_0110, // 18 R8 factor drops to 2, count exceeds
    8'b0110_0001, // 19 R6 io flag set
    8'b1000_0000, // 20 R1 reset clears flag
    8'b0111_0000, // 21 R3 count 1
    8'b0111_0000, // 22 R3 count 2
    8'b1111_0000, // 23 R1 reset beats strobe
    8'b0111_0000, // 24 R1 count restarted: 1
    8'b0111_0000, // 25 R1 count 2
    8'b0111_0010  // 26 R1 request on third after reset
  };
  localparam int TAG [NV] = '{1,3,10,3,3,5,4,4,9,9,2,2,9,6,6,2,7,8,8,6,1,3,3,1,1,1,1};

  task automatic step_cycle(input logic r, s, f, x, w, fx, input logic ex, io, input int req);
    @(negedge clk);
    rst = r; acc_stb = s; fast_clk = f; xlat_en = x; win_en = w; fast_xlat = fx;
    @(posedge clk);
    #2;
    applied++;
    if (extra_clk !== ex || io_wait !== io) begin
      errors++;
      $display("FAIL R%0d: extra_clk=%b io_wait=%b expected %b %b", req, extra_clk, io_wait, ex, io);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #2;
    applied++;
    // R1 reset state
    if (extra_clk !== 1'b0 || io_wait !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset extra_clk=%b io_wait=%b expected 0 0", extra_clk, io_wait);
    end
    for (int i = 0; i < NV; i++) begin
      step_cycle(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2],
                 VEC[i][1], VEC[i][0], TAG[i]);
    end
    // R10 long idle with translation on: nothing happens
    for (int i = 0; i < 5; i++) step_cycle(0, 0, 1, 1, 0, 0, 0, 0, 10);
    // R4 R5 back-to-back fast strobes: request every second, one cycle wide
    for (int i = 0; i < 6; i++) step_cycle(0, 1, 1, 1, 0, 1, logic'(i % 2), 0, 5);
    step_cycle(0, 0, 1, 1, 0, 1, 0, 0, 5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule